// File: doc/BRIEF.md
# Code-Gated Protected Memory Region Guard

This guard sits beside a memory bus and rules on every access that touches a single protected address window. Two 16-bit border values define the window. They are compared against the upper 16 bits of the bus address, so the window has a granularity of 16 bytes on the default 20-bit bus. A CPU may read or write data inside the window only while it is running code from inside the window. The guard tracks this with a data-enable flag. Each CPU code fetch updates the flag. A fetch from outside the window clears it. A fetch from the first few bytes of the window, which are reserved for a descriptor of the window, also clears it.

Requesters other than the CPU never reach the window. The interrupt-vector range at the top of the 64K space stays open to everyone. When an access is refused, the guard does three things. It substitutes a jump-to-self opcode on the read data path. It blocks the memory write strobe. It raises a one-cycle violation pulse, which is also latched into a sticky flag. If enabled, it also asks for a system reset. The `grant` output is meant to feed a later segment-permission stage.

Top module: `ipguard`

## Requirements
- R1: The lower border is the smaller and the upper border the larger of `bord_a` and `bord_b`, whichever input carries which. Equal borders give an empty window.
- R2: An address is in the window when `addr[19:4]` is greater than or equal to the lower border and strictly less than the upper border.
- R3: Encoding: `src` 0 = CPU, 1 = DMA, 2 and 3 = debug port. A non-CPU access to an in-window address outside the vector range is refused.
- R4: Encoding: `kind` 0 = code fetch, 1 and 3 = data read, 2 = data write. A CPU fetch is always granted. A CPU data access in the window is granted only if the flag is set. The flag is written on the clock edge of each valid CPU fetch: it becomes 1 for a fetch inside the window past its head, and 0 for any fetch outside the window. Accesses in the same cycle use the old flag value.
- R5: A CPU fetch from the first 8 bytes of the window (byte addresses from lower border × 16 up to 7 above that) clears the flag.
- R6: Addresses 0x0FF80 to 0x0FFFF are granted to every requester and every kind of access.
- R7: Addresses outside the window are granted to every requester.
- R8: A refused access other than a write returns 16'h3FFF on `rd_data`. Otherwise `rd_data` equals `mem_rdata`. `mem_we` is 1 only for a valid, granted write.
- R9: `viol_irq` is 1 for exactly the one cycle after each refused valid access. `viol_flag` is set in that same cycle and stays set until `viol_clr` is asserted. A new violation takes priority over a clear in the same cycle.
- R10: `reset_req` pulses together with `viol_irq` when `rst_on_viol` was 1 during the refused access.
- R11: After reset the data-enable flag, `viol_irq`, `viol_flag` and `reset_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | Access type (fetch/read/write) |
| acc_src | input | 2 | Requester (CPU/DMA/debug) |
| addr | input | 20 | Byte address |
| bord_a | input | 16 | Border value one |
| bord_b | input | 16 | Border value two |
| rst_on_viol | input | 1 | Request reset on a violation |
| viol_clr | input | 1 | Clears the sticky violation flag |
| mem_rdata | input | 16 | Data returned by memory |
| grant | output | 1 | Access allowed by this stage |
| rd_data | output | 16 | Read data, substituted when refused |
| mem_we | output | 1 | Write strobe to memory |
| viol_irq | output | 1 | One-cycle violation pulse |
| viol_flag | output | 1 | Sticky violation status |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach is a CPU data access that lands in the window right after a fetch from the window's 8-byte head. Only the stored flag tells that access apart from a legal one. Random addresses almost never produce this ordering. The stimulus therefore sometimes steers fetches into the head, the body or the vector range of the current window, and then follows them with data accesses in the window. A bench-side model of the flag predicts each grant. Border pairs are sometimes swapped or made equal so that the border ordering and the empty window are both covered.

// File: rtl/ipguard.sv
module ipguard #(
  parameter int ADDR_W     = 20,
  parameter int BORDER_W   = 16,
  parameter int DATA_W     = 16,
  parameter int HEAD_BYTES = 8,
  parameter logic [ADDR_W-1:0] VEC_LO = 20'h0FF80,
  parameter logic [ADDR_W-1:0] VEC_HI = 20'h0FFFF,
  parameter logic [DATA_W-1:0] SUBST  = 16'h3FFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic [1:0]          acc_kind,
  input  logic [1:0]          acc_src,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BORDER_W-1:0] bord_a,
  input  logic [BORDER_W-1:0] bord_b,
  input  logic                rst_on_viol,
  input  logic                viol_clr,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                grant,
  output logic [DATA_W-1:0]   rd_data,
  output logic                mem_we,
  output logic                viol_irq,
  output logic                viol_flag,
  output logic                reset_req
);
  localparam int SHIFT = ADDR_W - BORDER_W;
  localparam logic [ADDR_W-1:0] HEAD = ADDR_W'(HEAD_BYTES);

  logic [BORDER_W-1:0] lo, hi, seg;
  logic [ADDR_W-1:0]   base, off;
  logic in_win, in_head, in_vec, is_cpu, is_fetch, is_write, deny, cpu_fetch;
  logic data_en;

  assign lo   = (bord_a < bord_b) ? bord_a : bord_b;
  assign hi   = (bord_a < bord_b) ? bord_b : bord_a;
  assign seg  = addr[ADDR_W-1:SHIFT];
  assign base = {lo, {SHIFT{1'b0}}};
  assign off  = addr - base;

  assign in_win   = (seg >= lo) && (seg < hi);
  assign in_head  = in_win && (off < HEAD);
  assign in_vec   = (addr >= VEC_LO) && (addr <= VEC_HI);
  assign is_cpu   = (acc_src == 2'd0);
  assign is_fetch = (acc_kind == 2'd0);
  assign is_write = (acc_kind == 2'd2);
  assign cpu_fetch = acc_valid && is_cpu && is_fetch;

  always_comb begin
    if (in_vec || !in_win) grant = 1'b1;
    else if (!is_cpu)      grant = 1'b0;
    else if (is_fetch)     grant = 1'b1;
    else                   grant = data_en;
  end

  assign deny    = acc_valid && !grant;
  assign rd_data = (deny && !is_write) ? SUBST : mem_rdata;
  assign mem_we  = acc_valid && is_write && grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_en   <= 1'b0;
      viol_irq  <= 1'b0;
      viol_flag <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      if (cpu_fetch) data_en <= in_win && !in_head;
      viol_irq  <= deny;
      reset_req <= deny && rst_on_viol;
      if (deny)          viol_flag <= 1'b1;
      else if (viol_clr) viol_flag <= 1'b0;
    end
  end

  AST_NONCPU_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !is_cpu && in_win && !in_vec) |-> !grant); // R3
  AST_OUTSIDE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !in_win) |-> grant); // R7
  AST_VEC_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && in_vec) |-> grant); // R6
  AST_FETCH_OUT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fetch && !in_win) |=> !(acc_valid && is_cpu && !is_fetch && in_win && !in_vec && grant)); // R4
  AST_HEAD_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fetch && in_head) |=> !(acc_valid && is_cpu && !is_fetch && in_win && !in_vec && grant)); // R5
  AST_SUBST_ON_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !grant && !is_write) |-> (rd_data == SUBST)); // R8
  AST_NO_DENIED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |-> !mem_we); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !grant) |=> (viol_irq && viol_flag)); // R9
  AST_RST_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> viol_irq); // R10
endmodule

// File: tb/ipguard_test.sv
module ipguard_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, rst_on_viol = 0, viol_clr = 0;
  logic [1:0] acc_kind = 0, acc_src = 0;
  logic [19:0] addr = 0;
  logic [15:0] bord_a = 0, bord_b = 0, mem_rdata = 0;
  logic grant, mem_we, viol_irq, viol_flag, reset_req;
  logic [15:0] rd_data;

  int tests = 0, fails = 0;
  logic m_en = 0, m_irq = 0, m_flag = 0, m_rst = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipguard uut (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_src(acc_src), .addr(addr), .bord_a(bord_a), .bord_b(bord_b),
    .rst_on_viol(rst_on_viol), .viol_clr(viol_clr), .mem_rdata(mem_rdata),
    .grant(grant), .rd_data(rd_data), .mem_we(mem_we), .viol_irq(viol_irq),
    .viol_flag(viol_flag), .reset_req(reset_req));

  initial begin
    #(CLK_PERIOD*5000);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic f_inwin(input logic [19:0] a, input logic [15:0] x, input logic [15:0] y);
    logic [15:0] l, h;
    l = (x < y) ? x : y;
    h = (x < y) ? y : x;
    return (a[19:4] >= l) && (a[19:4] < h);
  endfunction

  function automatic logic f_head(input logic [19:0] a, input logic [15:0] x, input logic [15:0] y);
    logic [15:0] l;
    l = (x < y) ? x : y;
    return f_inwin(a, x, y) && (a - {l, 4'h0} < 20'd8);
  endfunction

  function automatic logic f_grant(input logic [19:0] a, input logic [1:0] k, input logic [1:0] s,
                                   input logic [15:0] x, input logic [15:0] y, input logic en);
    if (a >= 20'h0FF80 && a <= 20'h0FFFF) return 1'b1;
    if (!f_inwin(a, x, y)) return 1'b1;
    if (s != 2'd0) return 1'b0;
    if (k == 2'd0) return 1'b1;
    return en;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic [1:0] k, input logic [1:0] s, input logic [19:0] a,
                       input logic cl, input logic rv, input string tag);
    logic g, d;
    @(negedge clk);
    acc_valid = v; acc_kind = k; acc_src = s; addr = a; viol_clr = cl; rst_on_viol = rv;
    mem_rdata = 16'($urandom);
    #1;
    g = f_grant(a, k, s, bord_a, bord_b, m_en);
    d = v && !g;
    chk({tag, " grant"}, 32'(grant), 32'(g));
    chk("R8 rd_data", 32'(rd_data), (d && k != 2'd2) ? 32'h3FFF : 32'(mem_rdata));
    chk("R8 mem_we", 32'(mem_we), 32'(v && k == 2'd2 && g));
    if (v && s == 2'd0 && k == 2'd0) m_en = f_inwin(a, bord_a, bord_b) && !f_head(a, bord_a, bord_b);
    m_irq = d;
    m_rst = d && rv;
    if (d) m_flag = 1'b1; else if (cl) m_flag = 1'b0;
    @(posedge clk); #1;
    chk("R9 viol_irq", 32'(viol_irq), 32'(m_irq));
    chk("R9 viol_flag", 32'(viol_flag), 32'(m_flag));
    chk("R10 reset_req", 32'(reset_req), 32'(m_rst));
  endtask

  initial begin
    logic [15:0] lo;
    logic [15:0] hi;
    bord_a = 16'h0420; bord_b = 16'h0400;
    #(CLK_PERIOD*2 + 2);
    chk("R11 viol_irq", 32'(viol_irq), 0);
    chk("R11 viol_flag", 32'(viol_flag), 0);
    chk("R11 reset_req", 32'(reset_req), 0);
    rst_n = 1;
    // R11: data-enable starts clear, so an in-window CPU read is refused
    cycle(1, 2'd1, 2'd0, 20'h04050, 0, 0, "R11");
    // R5: head fetch (0x04000..0x04007) grants the fetch but leaves data closed
    cycle(1, 2'd0, 2'd0, 20'h04004, 0, 0, "R5");
    cycle(1, 2'd1, 2'd0, 20'h04100, 0, 0, "R5");
    // R4: fetch past the head opens data
    cycle(1, 2'd0, 2'd0, 20'h04008, 0, 0, "R4");
    cycle(1, 2'd2, 2'd0, 20'h04010, 0, 0, "R4");
    // R3: DMA and debug refused even while open
    cycle(1, 2'd1, 2'd1, 20'h04010, 0, 1, "R3");
    cycle(1, 2'd2, 2'd2, 20'h041F0, 0, 0, "R3");
    // R2: upper border exclusive, lower border inclusive
    cycle(1, 2'd1, 2'd1, 20'h04200, 0, 0, "R2");
    cycle(1, 2'd1, 2'd1, 20'h04000, 0, 0, "R2");
    // R4: fetch outside closes
    cycle(1, 2'd0, 2'd0, 20'h01000, 0, 0, "R4");
    cycle(1, 2'd1, 2'd0, 20'h04010, 0, 0, "R4");
    // R9: clear sticky, then violation beats clear
    cycle(0, 2'd1, 2'd0, 20'h0, 1, 0, "R9");
    cycle(1, 2'd1, 2'd3, 20'h04010, 1, 0, "R9");
    cycle(0, 2'd1, 2'd0, 20'h0, 1, 0, "R9");
    // R6: vector range inside a window covering it
    bord_a = 16'h0FFF; bord_b = 16'h0F00;
    cycle(1, 2'd2, 2'd1, 20'h0FF80, 0, 0, "R6");
    cycle(1, 2'd1, 2'd2, 20'h0FFFE, 0, 0, "R6");
    cycle(1, 2'd1, 2'd2, 20'h0FF70, 0, 0, "R6");
    // R1: equal borders give empty window
    bord_a = 16'h0500; bord_b = 16'h0500;
    cycle(1, 2'd1, 2'd1, 20'h05000, 0, 0, "R1");
    // R7: random outside and mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [19:0] a;
      logic [1:0] m;
      if (i % 200 == 0) begin
        bord_a = 16'($urandom_range(16'h0100, 16'h1100));
        bord_b = bord_a + 16'($urandom_range(0, 64));
        if ($urandom_range(0, 1) == 1) begin lo = bord_b; bord_b = bord_a; bord_a = lo; end
      end
      lo = (bord_a < bord_b) ? bord_a : bord_b;
      hi = (bord_a < bord_b) ? bord_b : bord_a;
      m = 2'($urandom_range(0, 3));
      if (m == 0) a = {lo, 4'h0} + 20'($urandom_range(0, 7));
      else if (m == 1 && hi > lo) a = {lo, 4'h0} + 20'($urandom_range(0, 32'(hi - lo) * 16 - 1));
      else if (m == 2) a = 20'h0FF80 + 20'($urandom_range(0, 127));
      else a = 20'($urandom);
      cycle($urandom_range(0, 7) != 0, 2'($urandom), ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'd0,
            a, $urandom_range(0, 3) == 0, 1'($urandom),
            f_inwin(a, bord_a, bord_b) ? "R1 R2 R4" : "R7");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial void'($urandom(32'd4242));
endmodule